// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block retunes one PLL out of a small bank when asked. A request carries a PLL index and a target output frequency in MHz, and a one-cycle start strobe launches it. The sequencer finds the divider settings for the frequency in a fixed table built for a 25 MHz reference. It then drives a simple register port through a fixed order. First it writes the main control word with the PLL held in reset and with power-down and bypass cleared. Next it writes the extended word and waits a settling time counted in clock cycles. It then writes the main word again with reset released, and polls the lock flag in bit 31 of the extended word.

The register port writes in a single cycle and reads combinationally. PLL `k` has its main control word at address `2k` and its extended word at address `2k+1`. The main word packs the feedback multiplier in bits [12:0], the input divider in [18:13], the post divider in [22:19], power-down in bit 23, bypass in bit 24 and reset in bit 25. Bits [31:26] belong to other logic and are carried over from a read of the same register. The sequencer ends every accepted request with a one-cycle `done_o` pulse or a one-cycle `err_o` pulse, and `err_code_o` holds the reason for the error.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o` and `wr_en_o` are all 0.
- R2: The first write of an accepted request goes to address 2k. Its bits [25:0] are reset=1, bypass=0, power-down=0, followed by P, N and M from the table entry. Its bits [31:26] equal those read from that address.
- R3: The write directly after the first one goes to address 2k+1. Its data is the table's extended value, zero-extended to 32 bits.
- R4: The release write is captured exactly WAIT_US*CLK_MHZ+1 clock cycles after the extended write is captured.
- R5: The release write goes to address 2k and carries the same bits as the first write except that reset (bit 25) is 0.
- R6: After the release write the sequencer polls bit 31 at address 2k+1. Once that bit reads 1 it pulses `done_o` for one cycle and issues no further write.
- R7: A frequency that is not in the table causes no write and produces `err_o` with code 2.
- R8: A PLL index of NUM_PLL or above causes no write and produces `err_o` with code 1. This check takes priority over the table lookup.
- R9: If the lock bit is not seen within POLL_MAX poll cycles, the request ends with `err_o` and code 3, after exactly three writes.
- R10: `busy_o` rises in the cycle after a start is accepted and stays high through the `done_o` or `err_o` cycle. A start strobe seen while busy is ignored. No write occurs while idle.
- R11: The table holds, keyed in MHz as (M, N, P, ext): 400 (95, 2, 1, 0x31), 200 (127, 0, 15, 0x3F), 334 (667, 4, 9, 0x14D), 1000 (119, 2, 0, 0x3D) and 50 (95, 2, 15, 0x31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| pll_sel_i | input | SEL_W | Index of the PLL to retune |
| freq_mhz_i | input | 11 | Target output frequency in MHz |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | ADDR_W | Register write address |
| wr_data_o | output | 32 | Register write data |
| rd_addr_o | output | ADDR_W | Register read address |
| rd_data_i | input | 32 | Combinational read data for `rd_addr_o` |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| err_code_o | output | 2 | Failure reason: 1 bad index, 2 no table entry, 3 lock timeout |

## Verification
The strobe sampled at edge E0 leads to the first write at edge E2 and the extended write at E3. The release write follows WAIT_US*CLK_MHZ+1 cycles after E3. `done_o` appears one cycle after the lock bit is first read as set. A rejected request raises `err_o` two cycles after the strobe. The bench samples every output at the falling edge, between the edges that change it. A scoreboard queue holds the expected write sequence, and each write is compared when it appears. The monitor stamps the extended and release writes with a cycle count to check the gap exactly. Outcomes are checked by waiting for the terminating pulse, and then the bench confirms that the queue is empty and that busy drops one cycle later.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
   localparam int FREQ_W = 11;
   localparam int M_W    = 13;
   localparam int N_W    = 6;
   localparam int P_W    = 4;
   localparam int EXT_W  = 12;
   localparam int TBL_N  = 5;

   // main control word bit positions (decoded by the PLL itself)
   localparam int PWRDN_BIT  = 23;
   localparam int BYPASS_BIT = 24;
   localparam int RESET_BIT  = 25;
   localparam int LOCK_BIT   = 31;

   typedef struct packed {
      logic [FREQ_W-1:0] mhz;
      logic [M_W-1:0]    m;
      logic [N_W-1:0]    n;
      logic [P_W-1:0]    p;
      logic [EXT_W-1:0]  ext;
   } pll_entry_t;

   typedef enum logic [1:0] {
      ERR_NONE     = 2'd0,
      ERR_BAD_PLL  = 2'd1,
      ERR_NO_ENTRY = 2'd2,
      ERR_NO_LOCK  = 2'd3
   } seq_err_e;

   function automatic pll_entry_t tbl_entry(input int idx);
      pll_entry_t e;
      case (idx)
         0:       e = '{mhz: 11'd400,  m: 13'd95,  n: 6'd2, p: 4'd1,  ext: 12'h031};
         1:       e = '{mhz: 11'd200,  m: 13'd127, n: 6'd0, p: 4'd15, ext: 12'h03F};
         2:       e = '{mhz: 11'd334,  m: 13'd667, n: 6'd4, p: 4'd9,  ext: 12'h14D};
         3:       e = '{mhz: 11'd1000, m: 13'd119, n: 6'd2, p: 4'd0,  ext: 12'h03D};
         default: e = '{mhz: 11'd50,   m: 13'd95,  n: 6'd2, p: 4'd15, ext: 12'h031};
      endcase
      return e;
   endfunction
endpackage

// File: rtl/pll_cfg_lookup.sv
module pll_cfg_lookup
   import pll_seq_pkg::*;
#(
   parameter int ENTRIES = TBL_N
) (
   input  logic [FREQ_W-1:0] mhz_i,
   output logic              hit_o,
   output pll_entry_t        ent_o
);
   if (ENTRIES < 1 || ENTRIES > TBL_N) begin : g_bad_entries
      $error("pll_cfg_lookup: ENTRIES out of range");
   end

   logic [ENTRIES-1:0] match;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      localparam pll_entry_t ROW = tbl_entry(g);
      assign match[g] = (mhz_i == ROW.mhz);
   end

   always_comb begin
      ent_o = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) ent_o = ent_o | tbl_entry(i);
      end
   end

   assign hit_o = |match;
endmodule

// File: rtl/pll_seq_cnt.sv
module pll_seq_cnt #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic last_o
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("pll_seq_cnt: LIMIT must be at least 1");
   end

   if (LIMIT == 1) begin : g_single
      logic unused_single;
      assign unused_single = clr_i ^ clk ^ rst_n;
      assign last_o = en_i;
   end else begin : g_count
      localparam int CW = $clog2(LIMIT + 1);
      logic [CW-1:0] cnt_q;

      assign last_o = en_i && (cnt_q == CW'(LIMIT - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt_q <= '0;
         else if (clr_i || last_o) cnt_q <= '0;
         else if (en_i)            cnt_q <= cnt_q + 1'b1;
      end

      // R4
      cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q < CW'(LIMIT));
   end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
   import pll_seq_pkg::*;
#(
   parameter int NUM_PLL  = 5,
   parameter int SEL_W    = 3,
   parameter int CLK_MHZ  = 2,
   parameter int WAIT_US  = 100,
   parameter int POLL_MAX = 64,
   localparam int ADDR_W  = $clog2(2 * NUM_PLL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [SEL_W-1:0]  pll_sel_i,
   input  logic [FREQ_W-1:0] freq_mhz_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [31:0]       wr_data_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [31:0]       rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [1:0]        err_code_o
);
   localparam int WAIT_CYC = CLK_MHZ * WAIT_US;

   if (NUM_PLL < 1) begin : g_bad_num
      $error("pll_reprog_seq: NUM_PLL must be at least 1");
   end
   if ((2 ** SEL_W) < NUM_PLL) begin : g_bad_sel
      $error("pll_reprog_seq: SEL_W too narrow for NUM_PLL");
   end
   if (SEL_W + 1 < ADDR_W) begin : g_bad_addr
      $error("pll_reprog_seq: SEL_W too narrow for address");
   end
   if (WAIT_CYC < 1 || POLL_MAX < 1) begin : g_bad_time
      $error("pll_reprog_seq: wait and poll limits must be positive");
   end

   typedef enum logic [3:0] {
      S_IDLE, S_CHK, S_WR1, S_WRX, S_WAIT, S_WR2, S_POLL, S_DONE, S_FAIL
   } seq_state_e;

   seq_state_e        state_q, state_d;
   logic [SEL_W-1:0]  sel_q;
   logic [FREQ_W-1:0] mhz_q;
   seq_err_e          code_q, code_d;

   logic       hit;
   pll_entry_t ent;
   logic       wait_last, poll_last;
   logic       locked;
   logic       bad_sel;

   logic [ADDR_W-1:0] main_addr, ext_addr;
   logic [RESET_BIT:0] cfg_hold, cfg_run;
   logic unused_rd;

   pll_cfg_lookup #(.ENTRIES(TBL_N)) u_lookup (
      .mhz_i (mhz_q),
      .hit_o (hit),
      .ent_o (ent)
   );

   pll_seq_cnt #(.LIMIT(WAIT_CYC)) u_wait_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state_q != S_WAIT),
      .en_i   (state_q == S_WAIT),
      .last_o (wait_last)
   );

   pll_seq_cnt #(.LIMIT(POLL_MAX)) u_poll_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state_q != S_POLL),
      .en_i   ((state_q == S_POLL) && !locked),
      .last_o (poll_last)
   );

   assign locked    = rd_data_i[LOCK_BIT];
   assign bad_sel   = (32'(sel_q) >= NUM_PLL);
   assign main_addr = ADDR_W'({sel_q, 1'b0});
   assign ext_addr  = ADDR_W'({sel_q, 1'b1});
   assign cfg_hold  = {1'b1, 1'b0, 1'b0, ent.p, ent.n, ent.m};
   assign cfg_run   = {1'b0, 1'b0, 1'b0, ent.p, ent.n, ent.m};
   assign unused_rd = ^rd_data_i[RESET_BIT:0];

   always_comb begin
      state_d = state_q;
      code_d  = code_q;
      case (state_q)
         S_IDLE: if (start_i) begin
            state_d = S_CHK;
            code_d  = ERR_NONE;
         end
         S_CHK: begin
            if (bad_sel) begin
               state_d = S_FAIL;
               code_d  = ERR_BAD_PLL;
            end else if (!hit) begin
               state_d = S_FAIL;
               code_d  = ERR_NO_ENTRY;
            end else begin
               state_d = S_WR1;
            end
         end
         S_WR1:  state_d = S_WRX;
         S_WRX:  state_d = S_WAIT;
         S_WAIT: if (wait_last) state_d = S_WR2;
         S_WR2:  state_d = S_POLL;
         S_POLL: begin
            if (locked) begin
               state_d = S_DONE;
            end else if (poll_last) begin
               state_d = S_FAIL;
               code_d  = ERR_NO_LOCK;
            end
         end
         S_DONE:  state_d = S_IDLE;
         S_FAIL:  state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         code_q  <= ERR_NONE;
         sel_q   <= '0;
         mhz_q   <= '0;
      end else begin
         state_q <= state_d;
         code_q  <= code_d;
         if (state_q == S_IDLE && start_i) begin
            sel_q <= pll_sel_i;
            mhz_q <= freq_mhz_i;
         end
      end
   end

   always_comb begin
      wr_en_o   = 1'b0;
      wr_addr_o = main_addr;
      wr_data_o = '0;
      rd_addr_o = ext_addr;
      case (state_q)
         S_WR1: begin
            rd_addr_o = main_addr;
            wr_en_o   = 1'b1;
            wr_data_o = {rd_data_i[31:RESET_BIT+1], cfg_hold};
         end
         S_WRX: begin
            wr_en_o   = 1'b1;
            wr_addr_o = ext_addr;
            wr_data_o = 32'(ent.ext);
         end
         S_WR2: begin
            rd_addr_o = main_addr;
            wr_en_o   = 1'b1;
            wr_data_o = {rd_data_i[31:RESET_BIT+1], cfg_run};
         end
         default: ;
      endcase
   end

   assign busy_o     = (state_q != S_IDLE);
   assign done_o     = (state_q == S_DONE);
   assign err_o      = (state_q == S_FAIL);
   assign err_code_o = code_q;

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !wr_en_o);

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && !err_o) |=> busy_o);

   // R2
   hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WR1) |-> (wr_en_o && wr_data_o[RESET_BIT]
                              && !wr_data_o[BYPASS_BIT] && !wr_data_o[PWRDN_BIT]));

   // R3
   ext_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WR1) |=> (wr_en_o && wr_addr_o[0]));

   // R5
   release_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WR2) |-> (wr_en_o && !wr_data_o[RESET_BIT] && !wr_addr_o[0]));

   // R6
   done_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(rd_data_i[LOCK_BIT]));

   // R7
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o) && !(err_o && wr_en_o));

   // R8
   bad_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_CHK && bad_sel) |=> (err_o && !wr_en_o));
endmodule

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_PLL  = 5;
   localparam int SEL_W    = 3;
   localparam int CLK_MHZ  = 2;
   localparam int WAIT_US  = 100;
   localparam int POLL_MAX = 64;
   localparam int ADDR_W   = $clog2(2 * NUM_PLL);
   localparam int GAP      = CLK_MHZ * WAIT_US + 1;
   localparam int LOCK_DLY = 10;
   localparam int DOG      = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [SEL_W-1:0]  pll_sel_i = '0;
   logic [10:0]       freq_mhz_i = '0;
   logic              wr_en_o;
   logic [ADDR_W-1:0] wr_addr_o, rd_addr_o;
   logic [31:0]       wr_data_o, rd_data_i;
   logic              busy_o, done_o, err_o;
   logic [1:0]        err_code_o;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pll_reprog_seq #(
      .NUM_PLL(NUM_PLL), .SEL_W(SEL_W), .CLK_MHZ(CLK_MHZ),
      .WAIT_US(WAIT_US), .POLL_MAX(POLL_MAX)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .pll_sel_i(pll_sel_i),
      .freq_mhz_i(freq_mhz_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
   );

   // register bank model with lock behaviour
   logic [31:0] regs [2*NUM_PLL];
   int          lock_cnt [NUM_PLL];
   logic        lock_en = 1'b1;
   logic        pre_we = 1'b0;
   int          pre_idx = 0;
   logic [31:0] pre_val = '0;

   assign rd_data_i = regs[rd_addr_o];

   always @(posedge clk) begin
      if (pre_we) regs[pre_idx] <= pre_val;
      for (int k = 0; k < NUM_PLL; k++) begin
         if (lock_cnt[k] > 0) begin
            lock_cnt[k] <= lock_cnt[k] - 1;
            if (lock_cnt[k] == 1) regs[2*k+1][31] <= 1'b1;
         end
      end
      if (wr_en_o) begin
         regs[wr_addr_o] <= wr_data_o;
         if (!wr_addr_o[0] && !wr_data_o[25] && lock_en)
            lock_cnt[wr_addr_o >> 1] <= LOCK_DLY;
      end
   end

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int ext_cyc = 0;
   logic [ADDR_W+31:0] exp_q [$];

   task automatic check(input logic ok, input string tag, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // write monitor / scoreboard
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && wr_en_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7/R8/R10 unexpected write", {wr_addr_o, wr_data_o}, 0);
         end else begin
            logic [ADDR_W+31:0] e;
            e = exp_q.pop_front();
            check({wr_addr_o, wr_data_o} == e, "R2/R3/R5 write", {wr_addr_o, wr_data_o}, e);
         end
         if (wr_addr_o[0]) ext_cyc <= cyc;
         else if (!wr_data_o[25])
            check(cyc - ext_cyc == GAP, "R4 settle gap", cyc - ext_cyc, GAP);
      end
      if (cyc > DOG) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, DOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   function automatic void tb_row(input int r, output int mhz, output int m,
                                  output int n, output int p, output int ext);
      case (r)
         0: begin mhz = 50;   m = 95;  n = 2; p = 15; ext = 'h31;  end
         1: begin mhz = 200;  m = 127; n = 0; p = 15; ext = 'h3F;  end
         2: begin mhz = 334;  m = 667; n = 4; p = 9;  ext = 'h14D; end
         3: begin mhz = 400;  m = 95;  n = 2; p = 1;  ext = 'h31;  end
         default: begin mhz = 1000; m = 119; n = 2; p = 0; ext = 'h3D; end
      endcase
   endfunction

   task automatic preload(input int idx, input logic [31:0] v);
      @(negedge clk);
      pre_we = 1'b1; pre_idx = idx; pre_val = v;
      @(negedge clk);
      pre_we = 1'b0;
   endtask

   task automatic push_seq(input int sel, input logic [5:0] up, input int r);
      int mhz, m, n, p, ext;
      logic [31:0] w;
      tb_row(r, mhz, m, n, p, ext);
      w = {up, 1'b1, 1'b0, 1'b0, p[3:0], n[5:0], m[12:0]};
      exp_q.push_back({ADDR_W'(2*sel), w});
      exp_q.push_back({ADDR_W'(2*sel+1), 32'(ext)});
      w[25] = 1'b0;
      exp_q.push_back({ADDR_W'(2*sel), w});
   endtask

   task automatic run_op(input int sel, input int mhz, input int want_code, input string tag);
      int t;
      @(negedge clk);
      start_i = 1'b1; pll_sel_i = SEL_W'(sel); freq_mhz_i = 11'(mhz);
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o, {tag, " R10 busy after start"}, busy_o, 1);
      t = 0;
      while (!done_o && !err_o && t < 2000) begin
         @(negedge clk);
         t++;
      end
      if (want_code == 0) begin
         check(done_o && !err_o, {tag, " R6 done"}, {done_o, err_o}, 2'b10);
      end else begin
         check(err_o && !done_o, {tag, " error pulse"}, {done_o, err_o}, 2'b01);
         check(err_code_o == 2'(want_code), {tag, " error code"}, err_code_o, want_code);
      end
      check(busy_o, {tag, " R10 busy on final cycle"}, busy_o, 1);
      check(exp_q.size() == 0, {tag, " all writes seen"}, exp_q.size(), 0);
      @(negedge clk);
      check(!busy_o && !done_o && !err_o, {tag, " R10 idle after"}, {busy_o, done_o, err_o}, 0);
   endtask

   initial begin
      for (int i = 0; i < 2*NUM_PLL; i++) regs[i] = 32'h0155_0AAA ^ (i << 27);
      for (int k = 0; k < NUM_PLL; k++) lock_cnt[k] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy_o && !done_o && !err_o && !wr_en_o, "R1 reset outputs",
            {busy_o, done_o, err_o, wr_en_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !wr_en_o, "R1 idle after reset", {busy_o, wr_en_o}, 0);

      // R11 every table row, distinct PLLs and upper bits
      for (int r = 0; r < 5; r++) begin
         int mhz, m, n, p, ext;
         logic [5:0] up;
         tb_row(r, mhz, m, n, p, ext);
         up = 6'(6'h2B + r * 7);
         preload(2*r, {up, 26'h3FF_FFFF});
         push_seq(r, up, r);
         run_op(r, mhz, 0, "R11 table row");
      end

      // R7 frequency absent from table
      run_op(1, 123, 2, "R7 no entry");
      // R8 index out of range, also with a valid frequency
      run_op(6, 400, 1, "R8 bad index");
      run_op(5, 999, 1, "R8 bad index priority");

      // R10 start while busy is ignored
      preload(6, 32'hFC00_0000);
      push_seq(3, 6'h3F, 2);
      @(negedge clk);
      start_i = 1'b1; pll_sel_i = 3'd3; freq_mhz_i = 11'd334;
      @(negedge clk);
      start_i = 1'b0;
      repeat (5) @(negedge clk);
      start_i = 1'b1; pll_sel_i = 3'd0; freq_mhz_i = 11'd50;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o, "R10 busy despite second start", busy_o, 1);
      while (!done_o && !err_o) @(negedge clk);
      check(done_o, "R10 original request completes", done_o, 1);
      check(exp_q.size() == 0, "R10 no extra writes", exp_q.size(), 0);
      @(negedge clk);

      // R9 lock never arrives
      lock_en = 1'b0;
      preload(4, 32'h0000_0000);
      push_seq(2, 6'h00, 3);
      run_op(2, 400, 3, "R9 lock timeout");
      lock_en = 1'b1;

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0 && !busy_o, "R6 quiet at end", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule